// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a computer-operating-properly watchdog for a small controller. The internal clock is first divided by four, and a binary counter then counts the divided ticks. If software fails to service the watchdog before the selected limit is reached, the block emits a one-cycle system reset request. That request is meant to re-initialise the chip in the same way as a power-on reset.

Servicing is a two-key ritual on a write-only service register. The byte 0x55 arms the tracker, and a later byte 0xAA restarts the count. Any amount of unrelated bus traffic may come between the two keys, as long as the watchdog does not expire first.

A byte-wide control register holds three things: the enable bit, a two-bit timeout select and a sticky flag recording that a timeout happened. The block sits on a simple register bus with address, write strobe, read strobe, write data and read data.

Top module: `kwd_watchdog`

## Requirements
- R1: After reset, `rst_req` is low and the control register reads 0x00 (watchdog disabled, select 0, flag clear).
- R2: The control register sits at `CTRL_ADDR`. Bit 0 is the enable, bits 2:1 are the timeout select, and bit 7 is the timeout flag. Bits 6:3 read as 0 and ignore writes. Read data is valid in the same cycle as the read strobe, and is 0 when the strobe is low.
- R3: With the watchdog enabled, `rst_req` rises exactly 4·2^(TAP_BASE+TAP_STEP·sel) clock edges after the edge that took the enabling write. The default taps are 2^15, 2^17, 2^19 and 2^21 prescaled ticks for select values 0 to 3.
- R4: `rst_req` is high for exactly one cycle. Counting restarts from zero on the edge that raises it, so the next request follows one full period later.
- R5: A write of 0x55 and then 0xAA to `SVC_ADDR` restarts the count. The next request comes one full period after the edge that took the 0xAA write.
- R6: Reads, writes to other addresses and control-register writes between the 0x55 and the 0xAA do not break the armed sequence.
- R7: A write of 0xAA to the service register that has no armed 0x55 before it is ignored, and the request keeps its original schedule.
- R8: A write of any value other than 0x55 or 0xAA to the service register while armed disarms it, so a following 0xAA is ignored.
- R9: A timeout discards a pending arm, so an 0xAA written after the request is ignored.
- R10: The flag is set on every timeout and survives it. Writing 0 to bit 7 clears the flag. Writing 1 to bit 7 leaves it unchanged. The reset input clears it.
- R11: While disabled, no request is generated and the count is held at zero. Re-enabling starts a full period.
- R12: Changing the select while counting does not clear the count, and the new limit applies at once. If the count already exceeds the new limit, the request follows at the next prescaled tick, within 4 clock edges.
- R13: Reading the service register returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Active-high asynchronous reset (power-on) |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and strobe |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Writes take effect on the rising edge that samples the strobe, and read data is valid within the same cycle as the strobe. The bench therefore samples reads one time unit after it drives them at the falling edge. The reset request rises on the edge that is exactly 4·2^n edges after the enabling or servicing write edge. The bench timestamps every rising edge with a counter and records the index of the write edge and of the edge behind the first falling-edge sample with `rst_req` high. It then compares the difference with the period, so late or early pulses show up as an exact mismatch. Pulse width is checked at the next falling edge, and the restart period is measured from the pulse edge itself.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
   localparam int unsigned BYTE_W       = 8;
   localparam int unsigned SEL_W        = 2;
   localparam int unsigned NUM_SEL      = 4;
   localparam logic [BYTE_W-1:0] KEY_ARM  = 8'h55;
   localparam logic [BYTE_W-1:0] KEY_FIRE = 8'hAA;
   localparam int unsigned CTL_EN_BIT   = 0;
   localparam int unsigned CTL_SEL_LSB  = 1;
   localparam int unsigned CTL_FLAG_BIT = 7;

   typedef struct packed {
      logic             flag;
      logic [SEL_W-1:0] sel;
      logic             en;
   } ctrl_t;

   typedef enum logic {
      KEY_IDLE  = 1'b0,
      KEY_ARMED = 1'b1
   } key_state_e;

   function automatic logic [BYTE_W-1:0] pack_ctrl(input ctrl_t c);
      logic [BYTE_W-1:0] b;
      b = '0;
      b[CTL_FLAG_BIT]             = c.flag;
      b[CTL_SEL_LSB +: SEL_W]     = c.sel;
      b[CTL_EN_BIT]               = c.en;
      return b;
   endfunction
endpackage

// File: rtl/kwd_prescaler.sv
module kwd_prescaler #(
   parameter int unsigned PRE_LOG2 = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   output logic tick
);
   generate
      if (PRE_LOG2 == 0) begin : g_bypass
         assign tick = 1'b1;
      end else begin : g_div
         logic [PRE_LOG2-1:0] pre_q;
         always_ff @(posedge clk or posedge rst) begin
            if (rst)      pre_q <= '0;
            else if (clr) pre_q <= '0;
            else          pre_q <= pre_q + 1'b1;
         end
         // tick marks the last input clock of each prescaled period
         assign tick = &pre_q;
      end
   endgenerate
endmodule

// File: rtl/kwd_key_tracker.sv
module kwd_key_tracker
   import kwd_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              svc_wr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              drop,
   output logic              armed,
   output logic              kick
);
   key_state_e st_q;

   assign armed = (st_q == KEY_ARMED);
   assign kick  = svc_wr && armed && (wdata == KEY_FIRE);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         st_q <= KEY_IDLE;
      end else if (svc_wr) begin
         // the first key (re)arms; the second key or any other byte disarms
         st_q <= (wdata == KEY_ARM) ? KEY_ARMED : KEY_IDLE;
      end else if (drop) begin
         st_q <= KEY_IDLE;
      end
   end
endmodule

// File: rtl/kwd_timeout_counter.sv
module kwd_timeout_counter
   import kwd_pkg::*;
#(
   parameter int unsigned TAP_BASE = 15,
   parameter int unsigned TAP_STEP = 2,
   parameter int unsigned CNT_W    = TAP_BASE + (NUM_SEL - 1) * TAP_STEP
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             tick,
   input  logic             kick,
   input  logic [SEL_W-1:0] sel,
   output logic             expire,
   output logic             req,
   output logic [CNT_W-1:0] cnt
);
   logic [CNT_W-1:0] lim_m1 [NUM_SEL];
   logic [CNT_W-1:0] cnt_q;

   generate
      for (genvar s = 0; s < NUM_SEL; s++) begin : g_tap
         localparam int unsigned EXP = TAP_BASE + s * TAP_STEP;
         assign lim_m1[s] = CNT_W'((64'd1 << EXP) - 64'd1);
      end
   endgenerate

   // >= so that a smaller limit selected mid-count fires at the next tick
   assign expire = en && tick && !kick && (cnt_q >= lim_m1[sel]);
   assign cnt    = cnt_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cnt_q <= '0;
         req   <= 1'b0;
      end else begin
         req <= expire;
         if (!en || kick || expire) cnt_q <= '0;
         else if (tick)             cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/kwd_ctrl_regs.sv
module kwd_ctrl_regs
   import kwd_pkg::*;
#(
   parameter bit EN_AT_RESET = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic             wr_flag,
   input  logic             set_flag,
   output ctrl_t            ctrl
);
   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         ctrl.flag <= 1'b0;
         ctrl.sel  <= '0;
         ctrl.en   <= EN_AT_RESET;
      end else begin
         if (wr) begin
            ctrl.en  <= wr_en;
            ctrl.sel <= wr_sel;
         end
         // a timeout in the same cycle beats a clearing write
         if (set_flag)            ctrl.flag <= 1'b1;
         else if (wr && !wr_flag) ctrl.flag <= 1'b0;
      end
   end
endmodule

// File: rtl/kwd_watchdog.sv
module kwd_watchdog
   import kwd_pkg::*;
#(
   parameter int unsigned       ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] SVC_ADDR    = 'h10,
   parameter logic [ADDR_W-1:0] CTRL_ADDR   = 'h11,
   parameter int unsigned       PRE_LOG2    = 2,
   parameter int unsigned       TAP_BASE    = 15,
   parameter int unsigned       TAP_STEP    = 2,
   parameter bit                EN_AT_RESET = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic              rst_req
);
   localparam int unsigned CNT_W = TAP_BASE + (NUM_SEL - 1) * TAP_STEP;

   generate
      if (TAP_BASE == 0) begin : g_err_base
         $error("kwd_watchdog: TAP_BASE must be at least 1");
      end
      if (TAP_STEP == 0) begin : g_err_step
         $error("kwd_watchdog: TAP_STEP must be at least 1");
      end
      if (CNT_W > 62) begin : g_err_width
         $error("kwd_watchdog: longest tap exceeds 62 bits");
      end
      if (PRE_LOG2 > 16) begin : g_err_pre
         $error("kwd_watchdog: PRE_LOG2 above 16 is not supported");
      end
      if (SVC_ADDR == CTRL_ADDR) begin : g_err_addr
         $error("kwd_watchdog: service and control addresses collide");
      end
   endgenerate

   logic             svc_wr;
   logic             ctrl_wr;
   logic             key_armed;
   logic             key_kick;
   logic             tick;
   logic             expire;
   logic [CNT_W-1:0] tmo_cnt;
   ctrl_t            ctrl;

   assign svc_wr  = bus_wr && (bus_addr == SVC_ADDR);
   assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);

   kwd_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
      .clk  (clk),
      .rst  (rst),
      .clr  (!ctrl.en || key_kick || expire),
      .tick (tick)
   );

   kwd_key_tracker u_keys (
      .clk    (clk),
      .rst    (rst),
      .svc_wr (svc_wr),
      .wdata  (bus_wdata),
      .drop   (expire),
      .armed  (key_armed),
      .kick   (key_kick)
   );

   kwd_timeout_counter #(
      .TAP_BASE (TAP_BASE),
      .TAP_STEP (TAP_STEP),
      .CNT_W    (CNT_W)
   ) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .en     (ctrl.en),
      .tick   (tick),
      .kick   (key_kick),
      .sel    (ctrl.sel),
      .expire (expire),
      .req    (rst_req),
      .cnt    (tmo_cnt)
   );

   kwd_ctrl_regs #(.EN_AT_RESET(EN_AT_RESET)) u_regs (
      .clk      (clk),
      .rst      (rst),
      .wr       (ctrl_wr),
      .wr_en    (bus_wdata[CTL_EN_BIT]),
      .wr_sel   (bus_wdata[CTL_SEL_LSB +: SEL_W]),
      .wr_flag  (bus_wdata[CTL_FLAG_BIT]),
      .set_flag (expire),
      .ctrl     (ctrl)
   );

   // the service register is write-only and reads back as zero
   always_comb begin
      bus_rdata = '0;
      if (bus_rd && (bus_addr == CTRL_ADDR)) bus_rdata = pack_ctrl(ctrl);
   end
endmodule

// File: rtl/kwd_watchdog_chk.sv
module kwd_watchdog_chk
   import kwd_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] SVC_ADDR  = 'h10,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h11,
   parameter int unsigned       CNT_W     = 21
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [BYTE_W-1:0] bus_wdata,
   input logic [BYTE_W-1:0] bus_rdata,
   input logic              rst_req,
   input logic              ctrl_en,
   input logic              ctrl_flag,
   input logic              armed,
   input logic              kick,
   input logic [CNT_W-1:0]  tmo_cnt
);
   p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
      rst_req |=> !rst_req)
      else $error("rst_req wider than one cycle");

   p_kick_clears_r5: assert property (@(posedge clk) disable iff (rst)
      kick |=> (tmo_cnt == '0))
      else $error("service sequence did not clear the count");

   p_lone_fire_r7: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == SVC_ADDR && bus_wdata == KEY_FIRE && !armed) |-> !kick)
      else $error("unarmed second key restarted the count");

   p_disarm_r8: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == SVC_ADDR && bus_wdata != KEY_ARM) |=> !armed)
      else $error("tracker stayed armed after a non-arming write");

   p_flag_on_timeout_r10: assert property (@(posedge clk) disable iff (rst)
      rst_req |-> ctrl_flag)
      else $error("timeout without flag");

   p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
      (ctrl_flag && !(bus_wr && bus_addr == CTRL_ADDR && !bus_wdata[CTL_FLAG_BIT])) |=> ctrl_flag)
      else $error("flag dropped without a clearing write");

   p_quiet_off_r11: assert property (@(posedge clk) disable iff (rst)
      !ctrl_en |=> (!rst_req && tmo_cnt == '0))
      else $error("disabled watchdog counted or fired");

   p_svc_read_zero_r13: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && bus_addr == SVC_ADDR) |-> (bus_rdata == '0))
      else $error("service register read returned data");
endmodule

bind kwd_watchdog kwd_watchdog_chk #(
   .ADDR_W    (ADDR_W),
   .SVC_ADDR  (SVC_ADDR),
   .CTRL_ADDR (CTRL_ADDR),
   .CNT_W     (CNT_W)
) i_chk (
   .clk       (clk),
   .rst       (rst),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .rst_req   (rst_req),
   .ctrl_en   (ctrl.en),
   .ctrl_flag (ctrl.flag),
   .armed     (key_armed),
   .kick      (key_kick),
   .tmo_cnt   (tmo_cnt)
);

// File: tb/test_kwd_watchdog.sv
module test_kwd_watchdog;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_SVC   = 8'h10;
   localparam logic [7:0] A_CTL   = 8'h11;
   localparam logic [7:0] A_OTHER = 8'h40;
   localparam int TB_BASE = 3;
   localparam int TB_STEP = 2;
   localparam int VEC_N   = 4;
   // {select, expected edges from enabling write to request}
   localparam logic [17:0] VEC [VEC_N] = '{
      {2'd0, 16'd32}, {2'd1, 16'd128}, {2'd2, 16'd512}, {2'd3, 16'd2048}
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       rst_req;
   int         cyc = 0;
   int         total = 0;
   int         bad = 0;

   kwd_watchdog #(
      .ADDR_W   (8),
      .SVC_ADDR (A_SVC),
      .CTRL_ADDR(A_CTL),
      .PRE_LOG2 (2),
      .TAP_BASE (TB_BASE),
      .TAP_STEP (TB_STEP)
   ) i_kwd_watchdog (
      .clk       (clk),
      .rst       (rst),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .rst_req   (rst_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int period(input int s);
      return 4 * (1 << (TB_BASE + TB_STEP * s));
   endfunction

   function automatic logic [7:0] cbyte(input logic fl, input logic [1:0] s, input logic en);
      return {fl, 4'b0000, s, en};
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic wait_pulse(input int maxc, output int t);
      t = -1;
      for (int i = 0; i < maxc; i++) begin
         if (rst_req) begin
            t = cyc;
            break;
         end
         @(negedge clk);
      end
   endtask

   task automatic report;
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog expired", cyc, 0);
      report();
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic [1:0] s;
      int exp_c, t0, ta, tp, tp2;

      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      check(rst_req == 1'b0, "R1 rst_req after reset", int'(rst_req), 0);
      rd_reg(A_CTL, d);
      check(d == 8'h00, "R1 control after reset", int'(d), 0);

      // R13 service register reads as zero
      rd_reg(A_SVC, d);
      check(d == 8'h00, "R13 service read", int'(d), 0);

      // R2 layout: unused bits ignored, flag write 0 keeps flag clear
      wr_reg(A_CTL, 8'h7B);
      rd_reg(A_CTL, d);
      check(d == 8'h03, "R2 control layout", int'(d), 3);
      wr_reg(A_CTL, 8'h00);
      @(negedge clk);
      check(bus_rdata == 8'h00, "R2 rdata idle", int'(bus_rdata), 0);

      // R3 / R4 / R10 table walk over the four selects
      for (int i = 0; i < VEC_N; i++) begin
         s     = VEC[i][17:16];
         exp_c = int'(VEC[i][15:0]);
         wr_reg(A_CTL, cbyte(1'b0, s, 1'b1));
         t0 = cyc;
         wait_pulse(exp_c + 50, tp);
         check(tp - t0 == exp_c, "R3 timeout period", tp - t0, exp_c);
         @(negedge clk);
         check(rst_req == 1'b0, "R4 pulse width", int'(rst_req), 0);
         rd_reg(A_CTL, d);
         check(d == cbyte(1'b1, s, 1'b1), "R10 flag set", int'(d), int'(cbyte(1'b1, s, 1'b1)));
         wait_pulse(exp_c + 50, tp2);
         check(tp2 - tp == exp_c, "R4 restart period", tp2 - tp, exp_c);
         wr_reg(A_CTL, 8'h80);
         rd_reg(A_CTL, d);
         check(d == 8'h80, "R10 flag survives", int'(d), 128);
         wr_reg(A_CTL, 8'h00);
         rd_reg(A_CTL, d);
         check(d == 8'h00, "R10 flag cleared by 0", int'(d), 0);
      end

      // R10 writing 1 to the flag does not set it
      wr_reg(A_CTL, 8'h80);
      rd_reg(A_CTL, d);
      check(d == 8'h00, "R10 flag write 1 no effect", int'(d), 0);

      // R5 / R6 service with unrelated traffic between the keys
      wr_reg(A_CTL, cbyte(1'b0, 2'd0, 1'b1));
      repeat (10) @(negedge clk);
      wr_reg(A_SVC, 8'h55);
      wr_reg(A_OTHER, 8'h77);
      rd_reg(A_CTL, d);
      wr_reg(A_CTL, cbyte(1'b0, 2'd0, 1'b1));
      wr_reg(A_SVC, 8'hAA);
      ta = cyc;
      wait_pulse(200, tp);
      check(tp - ta == period(0), "R5 R6 service restarts count", tp - ta, period(0));
      wr_reg(A_CTL, 8'h00);

      // R7 lone second key ignored
      wr_reg(A_CTL, cbyte(1'b0, 2'd0, 1'b1));
      t0 = cyc;
      repeat (10) @(negedge clk);
      wr_reg(A_SVC, 8'hAA);
      wait_pulse(200, tp);
      check(tp - t0 == period(0), "R7 unarmed 0xAA ignored", tp - t0, period(0));
      wr_reg(A_CTL, 8'h00);

      // R8 other byte disarms
      wr_reg(A_CTL, cbyte(1'b0, 2'd0, 1'b1));
      t0 = cyc;
      wr_reg(A_SVC, 8'h55);
      wr_reg(A_SVC, 8'h12);
      wr_reg(A_SVC, 8'hAA);
      wait_pulse(200, tp);
      check(tp - t0 == period(0), "R8 disarm by other byte", tp - t0, period(0));
      wr_reg(A_CTL, 8'h00);

      // R9 timeout discards the arm
      wr_reg(A_CTL, cbyte(1'b0, 2'd0, 1'b1));
      t0 = cyc;
      repeat (5) @(negedge clk);
      wr_reg(A_SVC, 8'h55);
      wait_pulse(200, tp);
      check(tp - t0 == period(0), "R9 first timeout", tp - t0, period(0));
      wr_reg(A_SVC, 8'hAA);
      wait_pulse(200, tp2);
      check(tp2 - tp == period(0), "R9 arm dropped by timeout", tp2 - tp, period(0));
      wr_reg(A_CTL, 8'h00);

      // R11 disabled: no request, count held at zero
      wait_pulse(300, tp);
      check(tp == -1, "R11 no request when disabled", tp, -1);
      wr_reg(A_CTL, cbyte(1'b0, 2'd0, 1'b1));
      repeat (20) @(negedge clk);
      wr_reg(A_CTL, 8'h00);
      wait_pulse(50, tp);
      check(tp == -1, "R11 disable mid-count", tp, -1);
      wr_reg(A_CTL, cbyte(1'b0, 2'd0, 1'b1));
      t0 = cyc;
      wait_pulse(200, tp);
      check(tp - t0 == period(0), "R11 full period after re-enable", tp - t0, period(0));
      wr_reg(A_CTL, 8'h00);

      // R12 shorter select past the count fires at next tick
      wr_reg(A_CTL, cbyte(1'b0, 2'd3, 1'b1));
      repeat (200) @(negedge clk);
      wr_reg(A_CTL, cbyte(1'b0, 2'd0, 1'b1));
      ta = cyc;
      wait_pulse(20, tp);
      check(tp != -1 && tp - ta >= 1 && tp - ta <= 4, "R12 shrink fires at next tick", tp - ta, 4);
      wr_reg(A_CTL, 8'h00);

      // R12 longer select keeps the count
      wr_reg(A_CTL, cbyte(1'b0, 2'd1, 1'b1));
      t0 = cyc;
      repeat (40) @(negedge clk);
      wr_reg(A_CTL, cbyte(1'b0, 2'd2, 1'b1));
      wait_pulse(1000, tp);
      check(tp - t0 == period(2), "R12 count kept on select change", tp - t0, period(2));
      wr_reg(A_CTL, 8'h00);

      // R10 / R1 reset input clears the flag
      wr_reg(A_CTL, cbyte(1'b0, 2'd0, 1'b1));
      wait_pulse(200, tp);
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      rd_reg(A_CTL, d);
      check(d == 8'h00, "R10 reset clears flag", int'(d), 0);
      check(rst_req == 1'b0, "R1 rst_req after second reset", int'(rst_req), 0);

      report();
      $finish;
   end
endmodule